// File: doc/BRIEF.md
# Nonvolatile Array Program-Sequence Controller

This block guards the path from a CPU bus to the latch and high-voltage controls of an on-chip nonvolatile array. Software opens a latch window, writes the target location through the ordinary bus, and then arms a program cycle through a single control register. The controller captures one address and data word, rejects control writes that arrive out of order, and runs an automatic program cycle that ends after a fixed number of clock cycles.

The array's contents are read through the same bus. While the latch window is open, a read of any array location does not return the cell contents. It returns the captured data word and moves the captured address to the address that was read. A read that arrives while a program cycle is running spoils that cycle, and a sticky status bit records the failure. The cells, charge pump and analog timing are outside this block. A cycle counter stands in for the program time.

Top module: `nvm_seq_ctrl`

## Requirements
- R1: A bus write is captured into the address/data latch only when the latch bit is set, the program bit is clear, and the address lies in [ARR_BASE, ARR_BASE+ARR_SIZE). Other writes leave `arr_addr` unchanged. The defaults are 0x0800 and 0x200.
- R2: When several in-range writes are captured in a row, the latch holds the address and data of the last one.
- R3: A bus read of an array address returns the captured data word when the latch bit is set, and the address latch takes the read address. When the latch bit is clear, the read returns `arr_rdata` and the latch does not change.
- R4: The control register sits at CTRL_ADDR (default 0x00F0) and reads back as bit0 program, bit1 latch, bits 3:2 mode (0 byte, 1 block, 2 bulk) and bit4 error. Other bits read as zero, and non-array, non-control addresses read as zero. A write that sets bit0 is ignored unless the latch bit is already set, the same write keeps bit1 set, and an in-range address has been captured.
- R5: After the program bit is set, it stays set for exactly PGM_CYCLES clock cycles and then clears itself. `pgm_done` is high for one cycle, in the first cycle that the program bit is low.
- R6: An array read while the program bit is set sets the error bit. The error bit stays set until a control write with bit4 = 1 clears it.
- R7: A control write while the program bit is set cannot clear the latch bit. A write of zero to both bits clears only the program bit.
- R8: Writes to the mode field take effect only while the program bit is clear.
- R9: Clearing the latch bit discards the captured address. A later program request is rejected until a new in-range write is captured.
- R10: After reset, the control register reads 0, `arr_addr` is 0, and `arr_hv_en` and `pgm_done` are low.
- R11: A program cycle that software ends early by writing bit0 = 0 produces no `pgm_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Bus address, also used by the array for reads |
| bus_wdata | input | DATA_W | Bus write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| arr_rdata | input | DATA_W | Cell contents at `bus_addr` from the array |
| arr_addr | output | ADDR_W | Captured target address |
| arr_data | output | DATA_W | Captured target data |
| arr_hv_en | output | 1 | Program bit, enables the high-voltage cycle |
| arr_mode | output | 2 | Operation size: byte, block or bulk |
| lat_en | output | 1 | Latch-window bit |
| pgm_done | output | 1 | One-cycle pulse when the timed cycle expires |
| pgm_err | output | 1 | Sticky failed-cycle status |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that each strobe lasts one cycle with a stable address. The error-bit and capture properties would be ambiguous if a read and a write arrived together. The stimulus drives every access from a task that raises one strobe for exactly one clock and lowers it before the next access. Reads during a program cycle are issued only on purpose, to spoil that cycle.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [1:0] {
        MODE_BYTE  = 2'd0,
        MODE_BLOCK = 2'd1,
        MODE_BULK  = 2'd2,
        MODE_RSVD  = 2'd3
    } nvm_mode_e;

    // Control register bit positions (software visible)
    localparam int unsigned CB_PGM  = 0;
    localparam int unsigned CB_LAT  = 1;
    localparam int unsigned CB_MODE = 2;
    localparam int unsigned CB_ERR  = 4;

    typedef struct packed {
        logic      err;
        nvm_mode_e mode;
        logic      lat;
        logic      pgm;
    } ctrl_t;

endpackage

// File: rtl/nvm_seq_range.sv
// In-range decode for the array window; picks a mask compare when the window is aligned.
module nvm_seq_range #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned ARR_BASE = 16'h0800,
    parameter int unsigned ARR_SIZE = 16'h0200
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(ARR_BASE);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(ARR_BASE + ARR_SIZE);
    localparam bit ALIGNED = ((ARR_SIZE & (ARR_SIZE - 1)) == 0)
                             && ((ARR_BASE % ARR_SIZE) == 0);
    localparam logic [ADDR_W-1:0] MASK = ~ADDR_W'(ARR_SIZE - 1);

    generate
        if (ALIGNED) begin : g_mask
            always_comb hit = ((addr & MASK) == (LO[ADDR_W-1:0] & MASK));
        end else begin : g_cmp
            logic [ADDR_W:0] wide;
            always_comb begin
                wide = {1'b0, addr};
                hit  = (wide >= LO) && (wide < HI);
            end
        end
    endgenerate
endmodule

// File: rtl/nvm_seq_capture.sv
// Address/data latch with validity flag.
module nvm_seq_capture #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic              lat_en,
    input  logic              pgm_en,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_valid
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!lat_en) begin
            st_d.valid = 1'b0;
        end else if (wr_hit && !pgm_en) begin
            st_d.addr  = bus_addr;
            st_d.data  = bus_wdata;
            st_d.valid = 1'b1;
        end else if (rd_hit) begin
            st_d.addr  = bus_addr;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_addr  = st_q.addr;
    assign cap_data  = st_q.data;
    assign cap_valid = st_q.valid;
endmodule

// File: rtl/nvm_seq_timer.sv
// Auto-clear timer for the program bit.
module nvm_seq_timer #(
    parameter int unsigned PGM_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pgm_en,
    output logic expire,
    output logic done
);
    localparam int unsigned CW = (PGM_CYCLES < 2) ? 1 : $clog2(PGM_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(PGM_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        expire     = pgm_en && (st_q.cnt == LAST);
        st_d       = st_q;
        st_d.done  = expire;
        if (!pgm_en || expire) st_d.cnt = '0;
        else                   st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
endmodule

// File: rtl/nvm_seq_ctrlreg.sv
// Control register with ordering interlocks.
module nvm_seq_ctrlreg
    import nvm_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cap_valid,
    input  logic              expire,
    input  logic              rd_hit,
    output ctrl_t             ctrl
);
    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (expire)              st_d.pgm = 1'b0;
        if (st_q.pgm && rd_hit)  st_d.err = 1'b1;
        if (ctrl_wr) begin
            if (wdata[CB_ERR]) st_d.err = 1'b0;
            if (!st_q.pgm) begin
                st_d.lat  = wdata[CB_LAT];
                st_d.mode = nvm_mode_e'(wdata[CB_MODE +: 2]);
                if (wdata[CB_PGM] && wdata[CB_LAT] && st_q.lat && cap_valid)
                    st_d.pgm = 1'b1;
            end else if (!wdata[CB_PGM]) begin
                st_d.pgm = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q;
endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
    import nvm_seq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ARR_BASE   = 16'h0800,
    parameter int unsigned ARR_SIZE   = 16'h0200,
    parameter int unsigned CTRL_ADDR  = 16'h00F0,
    parameter int unsigned PGM_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              arr_hv_en,
    output logic [1:0]        arr_mode,
    output logic              lat_en,
    output logic              pgm_done,
    output logic              pgm_err
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam int unsigned       CTRL_W = $bits(ctrl_t);

    logic  in_arr, wr_hit, rd_hit, ctrl_sel, cap_valid, expire;
    ctrl_t ctrl;

    nvm_seq_range #(.ADDR_W(ADDR_W), .ARR_BASE(ARR_BASE), .ARR_SIZE(ARR_SIZE)) u_range (
        .addr (bus_addr),
        .hit  (in_arr)
    );

    assign wr_hit   = bus_wr && in_arr;
    assign rd_hit   = bus_rd && in_arr;
    assign ctrl_sel = (bus_addr == CTRL_A);

    nvm_seq_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit),
        .lat_en    (ctrl.lat),
        .pgm_en    (ctrl.pgm),
        .cap_addr  (arr_addr),
        .cap_data  (arr_data),
        .cap_valid (cap_valid)
    );

    nvm_seq_timer #(.PGM_CYCLES(PGM_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pgm_en (ctrl.pgm),
        .expire (expire),
        .done   (pgm_done)
    );

    nvm_seq_ctrlreg #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (bus_wr && ctrl_sel),
        .wdata     (bus_wdata),
        .cap_valid (cap_valid),
        .expire    (expire),
        .rd_hit    (rd_hit),
        .ctrl      (ctrl)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (ctrl_sel)      bus_rdata = DATA_W'(CTRL_W'(ctrl));
            else if (in_arr)   bus_rdata = ctrl.lat ? arr_data : arr_rdata;
        end
    end

    assign arr_hv_en = ctrl.pgm;
    assign arr_mode  = ctrl.mode;
    assign lat_en    = ctrl.lat;
    assign pgm_err   = ctrl.err;
endmodule

// File: rtl/nvm_seq_ctrl_chk.sv
module nvm_seq_ctrl_chk #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ARR_BASE   = 16'h0800,
    parameter int unsigned ARR_SIZE   = 16'h0200,
    parameter int unsigned PGM_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              arr_hv_en,
    input logic [1:0]        arr_mode,
    input logic              lat_en,
    input logic              pgm_done,
    input logic              pgm_err
);
    localparam int unsigned CW = $clog2(PGM_CYCLES + 2);

    logic          arr_sel;
    logic [CW-1:0] hv_run;

    assign arr_sel = ({1'b0, bus_addr} >= (ADDR_W+1)'(ARR_BASE))
                  && ({1'b0, bus_addr} <  (ADDR_W+1)'(ARR_BASE + ARR_SIZE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hv_run <= '0;
        else if (!arr_hv_en) hv_run <= '0;
        else                 hv_run <= hv_run + 1'b1;
    end

    AST_HV_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        arr_hv_en |-> lat_en);                                               // R7
    AST_HV_RISE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_hv_en) |-> $past(lat_en));                                 // R4
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_hv_en && $past(arr_hv_en)) |-> $stable(arr_mode));              // R8
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_done |-> $fell(arr_hv_en));                                      // R5
    AST_HV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        hv_run <= CW'(PGM_CYCLES));                                          // R5
    AST_ERR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && arr_sel && arr_hv_en) |=> pgm_err);                       // R6
    AST_NO_CAPTURE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_en |=> $stable(arr_addr));                                      // R1
endmodule

bind nvm_seq_ctrl nvm_seq_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_BASE(ARR_BASE),
    .ARR_SIZE(ARR_SIZE), .PGM_CYCLES(PGM_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .arr_addr(arr_addr), .arr_hv_en(arr_hv_en), .arr_mode(arr_mode),
    .lat_en(lat_en), .pgm_done(pgm_done), .pgm_err(pgm_err)
);

// File: tb/nvm_seq_ctrl_bench.sv
module nvm_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 16;
    localparam logic [15:0] CTRL = 16'h00F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_rdata, arr_rdata, arr_data;
    logic [15:0] arr_addr;
    logic        arr_hv_en, lat_en, pgm_done, pgm_err;
    logic [1:0]  arr_mode;

    int n_chk = 0, n_fail = 0;
    logic [7:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign arr_rdata = bus_addr[7:0] ^ 8'h5A;

    nvm_seq_ctrl #(.PGM_CYCLES(NCYC)) u_nvm_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .arr_rdata(arr_rdata), .arr_addr(arr_addr), .arr_data(arr_data),
        .arr_hv_en(arr_hv_en), .arr_mode(arr_mode), .lat_en(lat_en),
        .pgm_done(pgm_done), .pgm_err(pgm_err)
    );

    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp_rd;
        logic [15:0] exp_aaddr;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{1'b1, 16'h00F0, 8'h00, 8'h00, 16'h0000},  // R10 reset readback
        '{1'b1, 16'h0810, 8'h00, 8'h4A, 16'h0000},  // R3 latch closed: array data
        '{1'b0, 16'h0810, 8'h77, 8'h00, 16'h0000},  // R1 latch closed: no capture
        '{1'b0, 16'h00F0, 8'h01, 8'h00, 16'h0000},  // R4 program without latch
        '{1'b1, 16'h00F0, 8'h00, 8'h00, 16'h0000},  // R4 rejected
        '{1'b0, 16'h00F0, 8'h02, 8'h00, 16'h0000},  // R4 open latch
        '{1'b0, 16'h00F0, 8'h03, 8'h00, 16'h0000},  // R4 program with nothing captured
        '{1'b1, 16'h00F0, 8'h00, 8'h02, 16'h0000},  // R4 still rejected
        '{1'b0, 16'h0400, 8'h11, 8'h00, 16'h0000},  // R1 below window
        '{1'b0, 16'h0A00, 8'h11, 8'h00, 16'h0000},  // R1 one past window
        '{1'b0, 16'h0820, 8'h33, 8'h00, 16'h0820},  // R1 capture
        '{1'b0, 16'h09FF, 8'h44, 8'h00, 16'h09FF},  // R2 last write wins, top edge
        '{1'b1, 16'h0800, 8'h00, 8'h44, 16'h0800},  // R3 latched data, address follows read
        '{1'b0, 16'h00F0, 8'h0B, 8'h00, 16'h0800},  // R4 accepted, bulk mode
        '{1'b1, 16'h00F0, 8'h00, 8'h0B, 16'h0800}   // R4 program bit set
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 rd_val = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int cnt;
        logic saw_done;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 hv_en after reset", arr_hv_en, 0);
        check("R10 done after reset", pgm_done, 0);

        for (int i = 0; i < 15; i++) begin
            if (VECS[i].rd) begin
                rd(VECS[i].addr);
                check($sformatf("table row %0d rdata", i), rd_val, VECS[i].exp_rd);
            end else begin
                wr(VECS[i].addr, VECS[i].data);
            end
            check($sformatf("table row %0d arr_addr", i), arr_addr, VECS[i].exp_aaddr);
        end
        check("R2 captured data", arr_data, 8'h44);

        // Running cycle: mode write ignored, read spoils cycle
        wr(CTRL, 8'h07);
        rd(CTRL);  check("R8 mode frozen while programming", rd_val, 8'h0B);
        rd(16'h0800); check("R3 read during program returns latch", rd_val, 8'h44);
        rd(CTRL);  check("R6 error set by read during program", rd_val, 8'h1B);
        cnt = 0;
        while (!pgm_done && cnt < 100) begin @(negedge clk); cnt++; end
        check("R5 cycle completes", pgm_done, 1);
        rd(CTRL);  check("R5 R6 program cleared, error sticky", rd_val, 8'h1A);
        wr(CTRL, 8'h1A);
        rd(CTRL);  check("R6 write one clears error", rd_val, 8'h0A);

        // Exact cycle length
        @(negedge clk);
        bus_addr = CTRL; bus_wdata = 8'h0B; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        cnt = 0;
        while (arr_hv_en && cnt < 1000) begin cnt++; @(negedge clk); end
        check("R5 program length", cnt, NCYC);
        check("R5 done pulse after fall", pgm_done, 1);
        @(negedge clk);
        check("R5 done is one cycle", pgm_done, 0);
        rd(CTRL);  check("R5 self-clear keeps latch", rd_val, 8'h0A);

        // Clear both bits at once
        wr(CTRL, 8'h0B);
        wr(CTRL, 8'h00);
        saw_done = pgm_done;
        repeat (3) begin @(negedge clk); saw_done |= pgm_done; end
        check("R11 no done on manual clear", saw_done, 0);
        rd(CTRL);  check("R7 only program bit cleared", rd_val, 8'h0A);
        check("R8 mode kept", arr_mode, 2'd2);

        // Closing the latch drops the capture
        wr(CTRL, 8'h00);
        rd(CTRL);  check("R7 latch clears with program off", rd_val, 8'h00);
        wr(CTRL, 8'h03);
        wr(CTRL, 8'h03);
        rd(CTRL);  check("R9 stale capture rejected", rd_val, 8'h02);
        wr(16'h0810, 8'h99);
        wr(CTRL, 8'h03);
        rd(CTRL);  check("R9 fresh capture accepted", rd_val, 8'h03);
        check("R1 fresh capture data", arr_data, 8'h99);
        rd(16'h1234); check("R4 unmapped reads zero", rd_val, 8'h00);

        // Reset in mid-cycle
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 hv_en cleared by reset", arr_hv_en, 0);
        check("R10 address cleared by reset", arr_addr, 16'h0000);
        rd(CTRL);  check("R10 control cleared by reset", rd_val, 8'h00);

        finish_run();
    end
endmodule